// File: doc/BRIEF.md
# SPI Nonvolatile SRAM Command Controller

This block is the serial front end of a byte-wide memory with a nonvolatile shadow copy. It acts as an SPI slave in clock mode 0. While chip select is low, it shifts opcodes, addresses and data in MSB first and turns them into write strobes for an external 32K x 8 SRAM array. It also turns them into requests to a nonvolatile backend. The SPI pins are sampled in the system clock domain through two-flop synchronisers. Every SCK or chip-select edge therefore takes effect on the third system clock edge after the pin changes.

A burst write streams data bytes to consecutive addresses until chip select rises. Four single-byte special commands are also decoded:
- copy the array to the shadow (save)
- copy the shadow back to the array (restore)
- switch automatic saving on
- switch automatic saving off

A write-enable latch gates every one of these operations. It is cleared when chip select rises at the end of any of them. Each special command starts a fixed busy period, timed by a simple fixed-latency backend model. A status read reports the busy flag, the write-enable latch and the automatic-save setting at any time, including while the block is busy.

Top module: `nvsram_spi_ctrl`

## Requirements
- R1: After reset, the outputs are as follows:
  - `busy`, `autosave_on`, `mem_we`, `save_req`, `restore_req` and `spi_so_oe` are 0.
  - A status read shows the write-enable latch as 0.
- R2: The enable command 0x06 sets the write-enable latch when chip select rises after it, provided `busy` is low at that decision cycle.
- R3: Burst write opcode 0x02 takes a 16-bit address, MSB first. Bit 15 of the address is ignored and the low 15 bits give the first byte address. Each following data byte, D7 first, produces one `mem_we` pulse at the next consecutive address.
- R4: During a burst, the address after 0x7FFF is 0x0000.
- R5: A burst write is only carried out when the latch is set at the end of the opcode byte; otherwise no `mem_we` pulse occurs. Chip select rising after an accepted burst clears the latch.
- R6: `spi_so_oe` stays low for the whole of every write and special-command transaction.
- R7: Save opcode 0x3C with the latch set produces exactly one `save_req` pulse, starts `busy` and clears the latch. It does so even if no write happened since the previous save or restore.
- R8: Restore opcode 0x60 with the latch set produces exactly one `restore_req` pulse, starts `busy` and clears the latch.
- R9: Opcode 0x59 sets `autosave_on` and opcode 0x19 clears it. Each of them starts `busy` and clears the latch.
- R10: A special command sent while the latch is clear has no effect: no request pulse, no busy period, and no change to `autosave_on`.
- R11: `busy` lasts BUSY_CYCLES clocks. While it is high, every command except a status read is ignored. A status read (opcode 0x05) returns bit 0 = busy, bit 1 = latch, bit 2 = autosave_on and zeros above, on `spi_so` after the opcode.
- R12: Reset clears `autosave_on`, because the setting is held only in a volatile register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_si | input | 1 | SPI serial data in |
| spi_so | output | 1 | SPI serial data out (status byte) |
| spi_so_oe | output | 1 | Output enable for spi_so |
| mem_we | output | 1 | One-cycle SRAM write strobe |
| mem_addr | output | 15 | SRAM byte address |
| mem_wdata | output | 8 | SRAM write data |
| save_req | output | 1 | One-cycle request to copy the array to the shadow |
| restore_req | output | 1 | One-cycle request to copy the shadow to the array |
| autosave_on | output | 1 | Volatile automatic-save enable setting |
| busy | output | 1 | Backend sequence in progress |

## Verification
The end of a busy period and the chip-select rise that decides a single-byte command can land on the same clock. The decision rule is that the command uses the busy value held in that exact cycle. The bench provokes the collision with a sweep:
- It measures the busy length after a save.
- It repeats the save and sends an enable command.
- It releases chip select at a range of offsets that straddle the measured busy end.

For each offset, the bench samples `busy` in the decision cycle, two clock edges after release. It then reads the latch back through a status read, and the latch must be set exactly when the sampled `busy` was low.

// File: rtl/nvs_pkg.sv
// Shared opcodes and controller state encoding for the SPI nonvolatile
// SRAM command controller. Assumes 8-bit opcodes, MSB first.
package nvs_pkg;
    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_RDSTAT  = 8'h05;
    localparam logic [7:0] OP_SAVE    = 8'h3C;
    localparam logic [7:0] OP_RESTORE = 8'h60;
    localparam logic [7:0] OP_AS_ON   = 8'h59;
    localparam logic [7:0] OP_AS_OFF  = 8'h19;

    typedef enum logic [2:0] {
        ST_IDLE,    // chip select high or opcode not yet complete
        ST_ADDR_HI, // expecting address bits 15..8
        ST_ADDR_LO, // expecting address bits 7..0
        ST_DATA,    // streaming burst data
        ST_STATUS,  // shifting out status
        ST_SINGLE,  // one-byte command waiting for chip select rise
        ST_DROP     // transaction ignored until chip select rises
    } ctrl_state_t;
endpackage

// File: rtl/nvs_spi_rx.sv
// SPI mode-0 receiver in the system clock domain. Synchronises CS, SCK
// and SI with two flops each, detects edges and assembles bytes MSB
// first. Assumes SCK runs slower than a quarter of the system clock.
module nvs_spi_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              cs_start,
    output logic              cs_end,
    output logic              sck_rise,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(DATA_W);

    logic              cs_m, cs_s, cs_p;
    logic              sck_m, sck_s, sck_p;
    logic              si_m, si_s;
    logic [DATA_W-2:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    // Purpose: two-flop synchronisers plus previous-value flops for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_m, cs_s, cs_p}    <= 3'b111;
            {sck_m, sck_s, sck_p} <= 3'b000;
            {si_m, si_s}          <= 2'b00;
        end else begin
            {cs_m, cs_s, cs_p}    <= {cs_n, cs_m, cs_s};
            {sck_m, sck_s, sck_p} <= {sck, sck_m, sck_s};
            {si_m, si_s}          <= {si, si_m};
        end
    end

    assign cs_start  = cs_p & ~cs_s;
    assign cs_end    = ~cs_p & cs_s;
    assign sck_rise  = sck_s & ~sck_p & ~cs_s;
    assign byte_done = sck_rise && (bit_cnt == CNT_W'(DATA_W - 1));
    assign byte_val  = {shreg, si_s};

    // Purpose: shift register and bit counter, restarted at each CS fall.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_start) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg   <= byte_val[DATA_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nvs_backend.sv
// Abstract nonvolatile backend: a fixed-latency responder that holds
// busy for BUSY_CYCLES clocks after each start pulse.
module nvs_backend #(
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] remain;

    // Purpose: load the countdown on start, otherwise count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= CW'(BUSY_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R11
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/nvs_cmd_ctrl.sv
// Command decoder: handles burst writes, the write-enable latch, the
// four special commands and status reads. Assumes the receiver's
// strobes are single-cycle and that busy comes from the backend.
module nvs_cmd_ctrl #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              sck_rise,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              save_req,
    output logic              restore_req,
    output logic              nv_start,
    output logic              autosave_on,
    output logic              so,
    output logic              so_oe
);
    import nvs_pkg::*;

    ctrl_state_t       state;
    logic [7:0]        opc;
    logic [ADDR_W-1:0] addr;
    logic              wel;
    logic [DATA_W-1:0] sh_out;

    assign so_oe = (state == ST_STATUS);
    assign so    = sh_out[DATA_W-1];

    // Purpose: transaction state, address tracking and SRAM write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            opc       <= '0;
            addr      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (cs_start || cs_end) begin
                state <= ST_IDLE;
            end else if (byte_done) begin
                case (state)
                    ST_IDLE: begin
                        opc <= byte_val;
                        if (byte_val == OP_RDSTAT)
                            state <= ST_STATUS;
                        else if (byte_val == OP_WRITE)
                            state <= (wel && !busy) ? ST_ADDR_HI : ST_DROP;
                        else
                            state <= ST_SINGLE;
                    end
                    ST_ADDR_HI: begin
                        addr[ADDR_W-1:8] <= byte_val[ADDR_W-9:0];
                        state            <= ST_ADDR_LO;
                    end
                    ST_ADDR_LO: begin
                        addr[7:0] <= byte_val;
                        state     <= ST_DATA;
                    end
                    ST_DATA: begin
                        mem_we    <= 1'b1;
                        mem_addr  <= addr;
                        mem_wdata <= byte_val;
                        addr      <= addr + 1'b1;
                    end
                    ST_SINGLE: state <= ST_DROP;
                    default:   state <= state;
                endcase
            end
        end
    end

    // Purpose: write-enable latch, special commands and backend requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel         <= 1'b0;
            autosave_on <= 1'b0;
            save_req    <= 1'b0;
            restore_req <= 1'b0;
            nv_start    <= 1'b0;
        end else begin
            save_req    <= 1'b0;
            restore_req <= 1'b0;
            nv_start    <= 1'b0;
            if (cs_end) begin
                if (state == ST_ADDR_HI || state == ST_ADDR_LO || state == ST_DATA)
                    wel <= 1'b0;
                else if (state == ST_SINGLE && !busy) begin
                    if (opc == OP_WREN)
                        wel <= 1'b1;
                    else if (wel && (opc == OP_SAVE || opc == OP_RESTORE ||
                                     opc == OP_AS_ON || opc == OP_AS_OFF)) begin
                        wel         <= 1'b0;
                        nv_start    <= 1'b1;
                        save_req    <= (opc == OP_SAVE);
                        restore_req <= (opc == OP_RESTORE);
                        if (opc == OP_AS_ON)  autosave_on <= 1'b1;
                        if (opc == OP_AS_OFF) autosave_on <= 1'b0;
                    end
                end
            end
        end
    end

    // Purpose: status shift-out register, loaded after the read opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_out <= '0;
        else if (byte_done && state == ST_IDLE && byte_val == OP_RDSTAT)
            sh_out <= DATA_W'({autosave_on, wel, busy});
        else if (sck_rise && state == ST_STATUS)
            sh_out <= {sh_out[DATA_W-2:0], 1'b0};
    end

    // R5
    write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);
    // R7
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, restore_req}));
    // R7
    req_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req || restore_req) |-> !wel);
    // R6
    so_quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !so_oe);
    // R11
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start |-> $past(!busy));
endmodule

// File: rtl/nvsram_spi_ctrl.sv
// Top level: SPI receiver, command decoder and backend busy model.
// Assumes an external 32K x 8 SRAM that accepts one write per strobe.
module nvsram_spi_ctrl #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              save_req,
    output logic              restore_req,
    output logic              autosave_on,
    output logic              busy
);
    logic              cs_start, cs_end, sck_rise, byte_done, nv_start;
    logic [DATA_W-1:0] byte_val;

    nvs_spi_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .si(spi_si),
        .cs_start(cs_start), .cs_end(cs_end), .sck_rise(sck_rise),
        .byte_done(byte_done), .byte_val(byte_val)
    );

    nvs_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .cs_end(cs_end),
        .sck_rise(sck_rise), .byte_done(byte_done), .byte_val(byte_val),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .save_req(save_req), .restore_req(restore_req),
        .nv_start(nv_start), .autosave_on(autosave_on),
        .so(spi_so), .so_oe(spi_so_oe)
    );

    nvs_backend #(.BUSY_CYCLES(BUSY_CYCLES)) u_nv (
        .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(busy)
    );
endmodule

// File: tb/nvsram_spi_ctrl_test.sv
module nvsram_spi_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic        so, so_oe, mem_we, save_req, restore_req, autosave_on, busy;
    logic [14:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0, failures = 0;
    logic [14:0] cap_a [0:31];
    logic [7:0]  cap_d [0:31];
    int cap_n = 0, save_n = 0, restore_n = 0, since_save = 0;
    bit oe_seen = 0, done = 0;

    always #10 clk = ~clk;

    nvsram_spi_ctrl uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .save_req(save_req), .restore_req(restore_req),
        .autosave_on(autosave_on), .busy(busy)
    );

    // Monitor: capture write strobes, request pulses and output enable.
    always @(posedge clk) begin
        if (mem_we && cap_n < 32) begin
            cap_a[cap_n] = mem_addr;
            cap_d[cap_n] = mem_wdata;
            cap_n++;
        end
        if (save_req) save_n++;
        if (restore_req) restore_n++;
        since_save = save_req ? 0 : since_save + 1;
        if (so_oe) oe_seen = 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        clks(4);
    endtask

    task automatic cs_high();
        sck = 1'b0;
        clks(4);
        cs_n = 1'b1;
        clks(8);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = tx[i];
            clks(4);
            rx[i] = so;
            sck = 1'b1;
            clks(4);
        end
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] r;
        cs_low();
        xfer(op, r);
        cs_high();
    endtask

    task automatic status(output logic [7:0] st);
        logic [7:0] r;
        cs_low();
        xfer(8'h05, r);
        xfer(8'h00, st);
        cs_high();
    endtask

    task automatic burst(input logic [15:0] a, input logic [7:0] d0, input int n);
        logic [7:0] r;
        cs_low();
        xfer(8'h02, r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
        for (int k = 0; k < n; k++) xfer(d0 + 8'(k), r);
        cs_high();
    endtask

    task automatic t_reset();
        logic [7:0] st;
        check(!busy && !autosave_on && !mem_we && !save_req && !restore_req && !so_oe,
              "R1 reset outputs", {busy, autosave_on, mem_we, so_oe}, 0);
        status(st);
        check(st == 8'h00, "R1 reset status", st, 0);
    endtask

    task automatic t_write_no_wel();
        logic [7:0] st;
        cap_n = 0;
        burst(16'h0100, 8'hA0, 2);
        check(cap_n == 0, "R5 write without latch", cap_n, 0);
        cmd(8'h06);
        status(st);
        check(st == 8'h02, "R2 enable sets latch", st, 8'h02);
    endtask

    task automatic t_burst();
        logic [7:0] st;
        cap_n = 0;
        oe_seen = 0;
        burst(16'h9234, 8'h5A, 3);
        check(cap_n == 3, "R3 write count", cap_n, 3);
        for (int k = 0; k < 3; k++)
            check(cap_a[k] == 15'h1234 + 15'(k) && cap_d[k] == 8'h5A + 8'(k),
                  "R3 burst byte", {cap_a[k], cap_d[k]}, {15'h1234 + 15'(k), 8'h5A + 8'(k)});
        check(!oe_seen, "R6 SO enable during write", oe_seen, 0);
        status(st);
        check(st == 8'h00, "R5 latch cleared after burst", st, 0);
    endtask

    task automatic t_wrap();
        cmd(8'h06);
        cap_n = 0;
        burst(16'h7FFF, 8'hC3, 2);
        check(cap_n == 2 && cap_a[0] == 15'h7FFF && cap_a[1] == 15'h0000,
              "R4 address wrap", cap_a[1], 0);
    endtask

    task automatic t_special_no_wel();
        int s0 = save_n;
        cmd(8'h3C);
        cmd(8'h59);
        check(save_n == s0 && !busy && !autosave_on, "R10 special ignored",
              {save_n - s0, busy, autosave_on}, 0);
    endtask

    task automatic t_save();
        logic [7:0] st;
        int s0 = save_n;
        cmd(8'h06);
        oe_seen = 0;
        cmd(8'h3C);
        check(save_n == s0 + 1 && busy, "R7 save pulse and busy", save_n - s0, 1);
        check(!oe_seen, "R6 SO enable during special", oe_seen, 0);
        cmd(8'h06);
        status(st);
        check(st == 8'h01, "R11 busy status, enable ignored", st, 8'h01);
        while (busy) clks(1);
        status(st);
        check(st == 8'h00, "R7 latch cleared", st, 0);
        cmd(8'h06);
        cmd(8'h3C);
        check(save_n == s0 + 2, "R7 repeated save", save_n - s0, 2);
        while (busy) clks(1);
    endtask

    task automatic t_restore_as();
        int r0 = restore_n, len = 0;
        cmd(8'h06);
        cmd(8'h60);
        check(restore_n == r0 + 1 && busy, "R8 restore pulse", restore_n - r0, 1);
        while (busy) begin clks(1); len++; end
        check(len > 150 && len < 210, "R11 busy length", len, 200);
        cmd(8'h06);
        cmd(8'h59);
        check(autosave_on && busy, "R9 autosave on", {autosave_on, busy}, 3);
        while (busy) clks(1);
        cmd(8'h06);
        cmd(8'h19);
        check(!autosave_on && busy, "R9 autosave off", {autosave_on, busy}, 1);
        while (busy) clks(1);
    endtask

    task automatic t_race();
        logic [7:0] st, r;
        int lneg = 0;
        bit bsamp;
        cmd(8'h06);
        cmd(8'h3C);
        while (busy) clks(1);
        lneg = since_save;
        for (int off = -2; off <= 2; off++) begin
            cmd(8'h06);
            cmd(8'h3C);
            cs_low();
            xfer(8'h06, r);
            sck = 1'b0;
            while (since_save != lneg + off - 2) clks(1);
            cs_n = 1'b1;
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            bsamp = busy;
            clks(8);
            while (busy) clks(1);
            status(st);
            check(st[1] == !bsamp, "R11 busy end versus enable", st[1], !bsamp);
            if (st[1]) begin cmd(8'h19); while (busy) clks(1); end
        end
    endtask

    task automatic t_reset_as();
        cmd(8'h06);
        cmd(8'h59);
        while (busy) clks(1);
        rst_n = 1'b0;
        clks(2);
        rst_n = 1'b1;
        clks(2);
        check(!autosave_on, "R12 autosave lost at reset", autosave_on, 0);
    endtask

    initial begin
        clks(4);
        rst_n = 1'b1;
        clks(4);
        t_reset();
        t_write_no_wel();
        t_burst();
        t_wrap();
        t_special_no_wel();
        t_save();
        t_restore_as();
        t_race();
        t_reset_as();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule